// File: doc/BRIEF.md
# Four-Bank Pin Controller with Edge Capture

This block controls 128 general-purpose pins, grouped as four banks of 32, through a small 32-bit register bus. Software sets each pin's direction, then sets or clears output bits through separate write-only strobes. It reads back a merged pin level and arms per-pin rising and falling edge capture. Captured edges are held in a sticky status word per bank, and software clears that word by writing ones.

Input pins pass through a two-flop synchroniser, and edges are found by comparing the synchronised level with its value one cycle earlier. Three interrupt outputs summarise the status bits: one for bank 0 pin 0, one for bank 0 pin 1, and one for every other pin. A one-cycle wake request fires when a pin on a fixed wake-capable list changes while it is an input. Each bank also has two alternate-function words, which are stored and read back and do nothing else.

Bus accesses are single-cycle. Writes take effect at the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational while `bus_sel` is high and `bus_wr` is low, and reads zero otherwise. Each bank has one synchronous register set and does not need a controlling state machine.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every register reads zero, `pin_oe` and `pin_out` are all zero, and all three interrupts and `wake_req` are low.
- R2: `pin_oe` bit n equals direction bit n (1 = output). `pin_out` bit n is the output latch bit while `pin_oe` is 1 and is 0 otherwise.
- R3: A write to a set strobe ORs the data into the output latch, and a read of that strobe returns the last value written to it. A write to a clear strobe clears the latch bits where the data holds ones, and a read of the clear strobe returns 0.
- R4: A level read returns, per bit, the latch for output pins and the synchronised input for input pins. A new input value shows up in this read two clock edges after it is applied.
- R5: When an input pin goes 0→1 and its rising-enable bit is set, its status bit is set. When it goes 1→0 and its falling-enable bit is set, its status bit is also set. Output pins never set status. Status is set on the third clock edge after the pin changes.
- R6: Status is sticky. A write to a status register clears the bits where the data holds ones. If an edge and a clear hit the same bit in the same cycle, the bit stays set.
- R7: `irq_pin0` equals bank 0 status bit 0. `irq_pin1` equals bank 0 status bit 1. `irq_other` is the OR of every other status bit in all four banks.
- R8: Byte offsets for bank b (b = 0..2) are: level 0x000+4b, direction 0x00C+4b, set 0x018+4b, clear 0x024+4b, rising 0x030+4b, falling 0x03C+4b, status 0x048+4b. Bank 3 uses the bank 0 offset plus 0x100. The alternate-function words are at 0x054+8b (low) and 0x058+8b (high) for b = 0..3, and they are plain storage.
- R9: Writes to the level register, and to any offset not listed in R8 (including offsets with nonzero low two bits), change no state. Reads of unlisted offsets return 0.
- R10: Wake-capable pins per bank are 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F. A change on such a pin while it is an input raises `wake_req` for exactly one cycle, after the third clock edge. Edge enables have no effect on `wake_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | 128 | Pad input levels, bank b at bits 32b+31..32b |
| pin_out | output | 128 | Pad output values |
| pin_oe | output | 128 | Pad output enables |
| irq_pin0 | output | 1 | Bank 0 pin 0 status |
| irq_pin1 | output | 1 | Bank 0 pin 1 status |
| irq_other | output | 1 | OR of all other status bits |
| wake_req | output | 1 | One-cycle wake pulse |

## Verification
Directed pin toggles on bank 0 pins 0 and 1 and on a bank 2 pin separate the three interrupt lines from one another. The same toggles on a pin switched to output show that output pins never set status. Toggles on a wake-capable pin and on a pin that is not wake-capable show that `wake_req` follows the fixed list and ignores the edge enables. Random register writes across all banks are mixed with random 128-bit pin patterns, and the full register file, pad outputs, interrupts and wake pulse are compared after each step. This exposes mistakes in the bank 3 offset, in the set/clear merge, in the per-bit level multiplexing, and in enable polarity. Writes to unlisted and misaligned offsets, followed by a full readback, show that nothing changed.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

    localparam int NUM_BANKS = 4;
    localparam int ADDR_W    = 9;

    typedef enum logic [3:0] {
        REG_LEVEL  = 4'd0,
        REG_DIR    = 4'd1,
        REG_SET    = 4'd2,
        REG_CLR    = 4'd3,
        REG_RISE   = 4'd4,
        REG_FALL   = 4'd5,
        REG_STAT   = 4'd6,
        REG_ALT_LO = 4'd7,
        REG_ALT_HI = 4'd8,
        REG_NONE   = 4'd9
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e   kind;
        logic [1:0]  bank;
    } reg_sel_t;

    // Fixed wake-capable pin lists, one word per bank
    function automatic logic [31:0] wake_bits(input int b);
        case (b)
            0:       return 32'h8003_FE1B;
            1:       return 32'h0020_01FC;
            2:       return 32'hEC08_0000;
            default: return 32'h0012_007F;
        endcase
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_ctrl_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    localparam int PER_KIND_WORDS = 21;   // 7 kinds x 3 low banks
    localparam int ALT_END        = 29;   // 8 alternate-function words

    logic [5:0] idx;
    logic [5:0] alt_idx;

    assign idx     = addr[7:2];
    assign alt_idx = idx - 6'(PER_KIND_WORDS);

    always_comb begin
        sel.kind = REG_NONE;
        sel.bank = 2'd0;
        if (addr[1:0] == 2'b00) begin
            if (!addr[8]) begin
                if (idx < 6'(PER_KIND_WORDS)) begin
                    sel.kind = reg_kind_e'(4'(idx / 6'd3));
                    sel.bank = 2'(idx % 6'd3);
                end else if (idx < 6'(ALT_END)) begin
                    sel.kind = alt_idx[0] ? REG_ALT_HI : REG_ALT_LO;
                    sel.bank = 2'(alt_idx >> 1);
                end
            end else if (idx < 6'(PER_KIND_WORDS) && (idx % 6'd3) == 6'd0) begin
                sel.kind = reg_kind_e'(4'(idx / 6'd3));
                sel.bank = 2'd3;
            end
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] level,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            level  <= '0;
            prev   <= '0;
        end else begin
            meta_q <= pin_in;
            level  <= meta_q;
            prev   <= level;
        end
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_ctrl_pkg::*;
#(
    parameter int           W    = 32,
    parameter logic [W-1:0] WAKE = '0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  reg_kind_e kind,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] level,
    input  logic [W-1:0] prev,
    output logic [W-1:0] rdata,
    output logic [W-1:0] latch,
    output logic [W-1:0] dir,
    output logic [W-1:0] status,
    output logic         wake_hit
);
    logic [W-1:0] set_last_q, rise_q, fall_q, alt_lo_q, alt_hi_q;
    logic [W-1:0] edge_up, edge_dn, stat_set, stat_clr;

    assign edge_up  = level & ~prev & ~dir;
    assign edge_dn  = ~level & prev & ~dir;
    assign stat_set = (edge_up & rise_q) | (edge_dn & fall_q);
    assign stat_clr = (wr_en && kind == REG_STAT) ? wdata : '0;
    assign wake_hit = |((edge_up | edge_dn) & WAKE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir        <= '0;
            latch      <= '0;
            set_last_q <= '0;
            rise_q     <= '0;
            fall_q     <= '0;
            alt_lo_q   <= '0;
            alt_hi_q   <= '0;
        end else if (wr_en) begin
            unique case (kind)
                REG_DIR:    dir    <= wdata;
                REG_SET: begin
                    latch      <= latch | wdata;
                    set_last_q <= wdata;
                end
                REG_CLR:    latch    <= latch & ~wdata;
                REG_RISE:   rise_q   <= wdata;
                REG_FALL:   fall_q   <= wdata;
                REG_ALT_LO: alt_lo_q <= wdata;
                REG_ALT_HI: alt_hi_q <= wdata;
                default: ;
            endcase
        end
    end

    // A new edge outranks a clear landing on the same bit
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~stat_clr) | stat_set;
    end

    always_comb begin
        unique case (kind)
            REG_LEVEL:  rdata = (latch & dir) | (level & ~dir);
            REG_DIR:    rdata = dir;
            REG_SET:    rdata = set_last_q;
            REG_RISE:   rdata = rise_q;
            REG_FALL:   rdata = fall_q;
            REG_STAT:   rdata = status;
            REG_ALT_LO: rdata = alt_lo_q;
            REG_ALT_HI: rdata = alt_hi_q;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_sel,
    input  logic                          bus_wr,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [DATA_W-1:0]             bus_rdata,
    input  logic [NUM_BANKS*DATA_W-1:0]   pin_in,
    output logic [NUM_BANKS*DATA_W-1:0]   pin_out,
    output logic [NUM_BANKS*DATA_W-1:0]   pin_oe,
    output logic                          irq_pin0,
    output logic                          irq_pin1,
    output logic                          irq_other,
    output logic                          wake_req
);
    localparam int PINS = NUM_BANKS * DATA_W;

    reg_sel_t         dec;
    logic [PINS-1:0]  lvl_s, prev_s, latch_all, dir_all, status_all;
    logic [DATA_W-1:0] bank_rd [NUM_BANKS];
    logic [NUM_BANKS-1:0] wake_hits;
    logic             do_write;

    assign do_write = bus_sel && bus_wr && dec.kind != REG_NONE;

    gpio_addr_decode u_dec (.addr(bus_addr), .sel(dec));

    gpio_in_sync #(.W(PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .level(lvl_s), .prev(prev_s)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        localparam logic [DATA_W-1:0] WM = DATA_W'(wake_bits(g));
        gpio_bank #(.W(DATA_W), .WAKE(WM)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (do_write && dec.bank == 2'(g)),
            .kind     (dec.kind),
            .wdata    (bus_wdata),
            .level    (lvl_s[g*DATA_W +: DATA_W]),
            .prev     (prev_s[g*DATA_W +: DATA_W]),
            .rdata    (bank_rd[g]),
            .latch    (latch_all[g*DATA_W +: DATA_W]),
            .dir      (dir_all[g*DATA_W +: DATA_W]),
            .status   (status_all[g*DATA_W +: DATA_W]),
            .wake_hit (wake_hits[g])
        );
    end

    assign bus_rdata = (bus_sel && !bus_wr) ? bank_rd[dec.bank] : '0;
    assign pin_oe    = dir_all;
    assign pin_out   = latch_all & dir_all;
    assign irq_pin0  = status_all[0];
    assign irq_pin1  = status_all[1];
    assign irq_other = |status_all[PINS-1:2];

    always_ff @(posedge clk) begin
        if (!rst_n) wake_req <= 1'b0;
        else        wake_req <= |wake_hits;
    end
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
    parameter int PINS = 128
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_sel,
    input logic            bus_wr,
    input logic [PINS-1:0] pin_oe,
    input logic [PINS-1:0] pin_out,
    input logic [PINS-1:0] status_all,
    input logic            irq_pin0,
    input logic            irq_other
);
    // R2: a pad is never driven high unless enabled
    a_r2_out_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);

    // R6: no status bit drops without a bus write
    a_r6_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> ((status_all & $past(status_all)) == $past(status_all)));

    // R5: bits newly set belong to pins that were inputs on the capturing edge
    a_r5_no_output_status: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_all & ~$past(status_all) & $past(pin_oe)) == '0));

    // R9: direction only moves on a bus write
    a_r9_dir_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> $stable(pin_oe));

    // R7: interrupt lines follow the status bits
    a_r7_irq_lines: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pin0 == status_all[0]) && (irq_other == |status_all[PINS-1:2]));
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.PINS(PINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .pin_oe     (pin_oe),
    .pin_out    (pin_out),
    .status_all (status_all),
    .irq_pin0   (irq_pin0),
    .irq_other  (irq_other)
);

// File: tb/gpio_bank_ctrl_test.sv
module gpio_bank_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0, bus_wr = 1'b0;
    logic [8:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [127:0] pin_in = '0;
    logic [127:0] pin_out, pin_oe;
    logic         irq_pin0, irq_pin1, irq_other, wake_req;

    int n_checks = 0;
    int n_errors = 0;

    // model state, kinds: 0 lvl 1 dir 2 set 3 clr 4 rise 5 fall 6 stat 7 altlo 8 althi
    logic [31:0] m_dir[4], m_lat[4], m_setl[4], m_rise[4], m_fall[4];
    logic [31:0] m_stat[4], m_alo[4], m_ahi[4], m_lvl[4];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank_ctrl uut (.*);

    function automatic logic [31:0] wake_of(int b);
        case (b)
            0: return 32'h8003FE1B;
            1: return 32'h002001FC;
            2: return 32'hEC080000;
            default: return 32'h0012007F;
        endcase
    endfunction

    function automatic logic [8:0] addr_of(int k, int b);
        int base;
        if (k >= 7) return 9'(32'h54 + 8*b + ((k == 8) ? 4 : 0));
        base = 12 * k;
        return (b == 3) ? 9'(base + 32'h100) : 9'(base + 4*b);
    endfunction

    function automatic logic [31:0] exp_read(int k, int b);
        case (k)
            0: return (m_lat[b] & m_dir[b]) | (m_lvl[b] & ~m_dir[b]);
            1: return m_dir[b];
            2: return m_setl[b];
            4: return m_rise[b];
            5: return m_fall[b];
            6: return m_stat[b];
            7: return m_alo[b];
            8: return m_ahi[b];
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [8:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic model_write(int k, int b, logic [31:0] d);
        case (k)
            1: m_dir[b] = d;
            2: begin m_lat[b] |= d; m_setl[b] = d; end
            3: m_lat[b] &= ~d;
            4: m_rise[b] = d;
            5: m_fall[b] = d;
            6: m_stat[b] &= ~d;
            7: m_alo[b] = d;
            8: m_ahi[b] = d;
            default: ;
        endcase
    endtask

    task automatic reg_write(int k, int b, logic [31:0] d);
        bus_write(addr_of(k, b), d);
        model_write(k, b, d);
    endtask

    task automatic check_all(string req);
        logic [31:0] rd;
        logic [127:0] e_oe, e_out;
        for (int b = 0; b < 4; b++) begin
            for (int k = 0; k < 9; k++) begin
                bus_read(addr_of(k, b), rd);
                check(req, 128'(rd), 128'(exp_read(k, b)));
            end
            e_oe[32*b +: 32]  = m_dir[b];
            e_out[32*b +: 32] = m_lat[b] & m_dir[b];
        end
        check({req, " R2 oe"}, pin_oe, e_oe);
        check({req, " R2 out"}, pin_out, e_out);
        check({req, " R7 irq"}, {125'd0, irq_pin0, irq_pin1, irq_other},
              {125'd0, m_stat[0][0], m_stat[0][1],
               (|m_stat[0][31:2]) | (|m_stat[1]) | (|m_stat[2]) | (|m_stat[3])});
    endtask

    // apply a pin pattern, update model edges and check the wake pulse (R10)
    task automatic drive_pins(logic [127:0] nv);
        logic exp_wake = 1'b0;
        for (int b = 0; b < 4; b++) begin
            logic [31:0] o = m_lvl[b], n = nv[32*b +: 32];
            logic [31:0] up = n & ~o & ~m_dir[b];
            logic [31:0] dn = ~n & o & ~m_dir[b];
            m_stat[b] |= (up & m_rise[b]) | (dn & m_fall[b]);
            if (((o ^ n) & ~m_dir[b] & wake_of(b)) != 0) exp_wake = 1'b1;
            m_lvl[b] = n;
        end
        @(negedge clk);
        pin_in = nv;
        repeat (3) @(posedge clk);
        #1 check("R10 wake pulse", 128'(wake_req), 128'(exp_wake));
        @(posedge clk);
        #1 check("R10 wake one cycle", 128'(wake_req), 128'd0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        void'($urandom(32'd20240611));
        for (int b = 0; b < 4; b++) begin
            m_dir[b] = 0; m_lat[b] = 0; m_setl[b] = 0; m_rise[b] = 0; m_fall[b] = 0;
            m_stat[b] = 0; m_alo[b] = 0; m_ahi[b] = 0; m_lvl[b] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1 check("R1 wake", 128'(wake_req), 128'd0);
        check_all("R1 reset");

        // R3 set/clear and R8 bank 3 offset
        reg_write(1, 3, 32'hFFFF_0000);
        reg_write(2, 3, 32'h00FF_FF00);
        reg_write(3, 3, 32'h000F_0F00);
        check("R8 bank3 oe", pin_oe[127:96], 128'hFFFF_0000);
        check("R3 latch merge", pin_out[127:96], 128'h00F0_0000);
        reg_write(7, 2, 32'hA5A5_0001);
        reg_write(8, 3, 32'h5A5A_0002);
        check_all("R3 R8 readback");

        // R5 R7 interrupt lines on bank 0 pins 0/1 and bank 2 pin 5
        reg_write(4, 0, 32'h0000_0003);
        reg_write(5, 2, 32'h0000_0020);
        drive_pins(128'h1);
        check("R7 pin0 irq", {irq_pin0, irq_pin1, irq_other}, 3'b100);
        drive_pins(128'h3);
        check("R7 pin1 irq", {irq_pin0, irq_pin1, irq_other}, 3'b110);
        drive_pins({32'h0, 32'h0000_0020, 32'h0, 32'h3});
        check("R5 falling not yet", 128'(irq_other), 128'd0);
        drive_pins(128'h3);
        check("R5 falling sets other", 128'(irq_other), 128'd1);
        // R6 write-one-to-clear
        reg_write(6, 0, 32'h1);
        check("R6 clear pin0", {irq_pin0, irq_pin1}, 2'b01);
        reg_write(6, 2, 32'hFFFF_FFFF);
        check_all("R6 after clears");

        // R5 output pin gives no status; R10 non-wake pin gives no wake
        reg_write(4, 0, 32'hFFFF_FFFF);
        reg_write(1, 0, 32'h0000_0004);
        drive_pins(128'h7);
        check("R5 output pin no status", 128'(m_stat[0][2]), 128'd0);
        reg_write(1, 0, 32'h0);
        drive_pins(128'h3);
        check_all("R4 R5 R10 directed");

        // R9 unmapped and level writes ignored
        bus_write(9'h0F0, 32'hFFFF_FFFF);
        bus_write(9'h154, 32'hFFFF_FFFF);
        bus_write(9'h104, 32'hFFFF_FFFF);
        bus_write(9'h00E, 32'hFFFF_FFFF);
        bus_write(9'h000, 32'hFFFF_FFFF);
        bus_read(9'h0F0, rd);
        check("R9 unmapped read", 128'(rd), 128'd0);
        bus_read(9'h104, rd);
        check("R9 bank3 hole read", 128'(rd), 128'd0);
        check_all("R9 nothing changed");

        // random phase
        for (int it = 0; it < 50; it++) begin
            for (int w = 0; w < 4; w++) begin
                int k = $urandom_range(0, 8);
                int b = $urandom_range(0, 3);
                reg_write(k, b, $urandom());
            end
            drive_pins({$urandom(), $urandom(), $urandom(), $urandom()});
            check_all("R2 R3 R4 R5 R6 random");
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule